// File: doc/BRIEF.md
# Conversion Result Byte Reader

This block sits between a 12-bit successive-approximation converter and an 8-bit host or DMA bus. It watches the converter's busy flag. When that flag drops, the result on the converter's data lines is known to be valid, so the block latches it and raises a transfer request for a DMA engine. The host then fetches the held result as two bytes, chosen by a one-bit byte address.

Two static options shape what the host sees. The packing option picks how the 12 bits are laid out across the two bytes. In the left-aligned layout the upper byte is a usable coarse 8-bit reading on its own. In the right-aligned layout the two bytes together read as an integer from 0 to 4095. The coding option flips the result's top bit when it is latched. With bipolar inputs this changes complementary offset binary into complementary two's complement. The live busy flag also shows up in a spare bit of the nibble byte, so software may poll for completion while it reads the low part of a result.

Top module: `conv_byte_reader`

## Requirements
- R1: After synchronous reset the transfer request is low and the held result is zero, so both byte addresses read 0x00 while the converter is idle.
- R2: The held result is loaded from the converter data lines on the clock edge that first samples the busy flag low after it was high, and is readable from the next cycle.
- R3: With the layout select high (left-aligned), byte address 0 returns result bits 11..4.
- R4: With the layout select high, byte address 1 returns result bits 3..0 in bits 7..4, zeros in bits 3..1 and the live busy flag in bit 0.
- R5: With the layout select low (right-aligned), byte address 0 returns result bits 7..0.
- R6: With the layout select low, byte address 1 returns the live busy flag in bit 7, zeros in bits 6..4 and result bits 11..8 in bits 3..0.
- R7: When the coding select is high at capture time, bit 11 of the held result is the inverse of the converter's bit 11, and bits 10..0 are unchanged.
- R8: The data output is 0x00 in any cycle where chip select or read strobe is low. With both high, the output reflects the addressed byte in that same cycle.
- R9: The transfer request goes high in the cycle after the busy flag is seen falling.
- R10: A read of byte address 1 clears the transfer request from the next cycle. A read of byte address 0 alone leaves it set.
- R11: A rising busy flag, which marks a new conversion, clears the transfer request from the next cycle.
- R12: Changes on the converter data lines without a busy fall leave the held result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_busy_i | input | 1 | Converter status, high while converting |
| conv_code_i | input | 12 | Converter result lines, bit 11 most significant |
| cfg_left_i | input | 1 | Layout select: 1 left-aligned, 0 right-aligned |
| cfg_flip_msb_i | input | 1 | Coding select: 1 inverts result bit 11 at capture |
| bus_cs_i | input | 1 | Chip select, active high |
| bus_rd_i | input | 1 | Read strobe, active high |
| bus_addr_i | input | 1 | Byte address: 0 main byte, 1 nibble/status byte |
| bus_data_o | output | 8 | Read data, zero when not selected |
| dma_req_o | output | 1 | Transfer request for a DMA engine |

## Verification
A wrong capture register shows up at the data port on the first read that follows a busy fall. The main byte and the nibble byte each expose a different slice of the result, so a bad bit is caught in one cycle whichever layout is active. A request flag stuck high or low shows up on dma_req_o one cycle after the fall, after a nibble read or after a new busy rise. The status bit is read while a conversion is in flight, so a stale or misplaced status bit is caught in the same read cycle.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    localparam int RES_W = 12;
    localparam int BUS_W = 8;
    localparam int NIB_W = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - NIB_W - 1;

    typedef enum logic {
        LAY_RIGHT = 1'b0,
        LAY_LEFT  = 1'b1
    } layout_e;

    typedef enum logic {
        SEL_MAIN = 1'b0,
        SEL_AUX  = 1'b1
    } bytesel_e;

    typedef struct packed {
        logic           cs;
        logic           rd;
        bytesel_e       sel;
    } bus_req_t;

    function automatic logic [BUS_W-1:0] pack_byte(
        input layout_e          lay,
        input bytesel_e         sel,
        input logic [RES_W-1:0] code,
        input logic             status
    );
        logic [BUS_W-1:0] b;
        unique case ({lay, sel})
            {LAY_LEFT,  SEL_MAIN}: b = code[RES_W-1 -: BUS_W];
            {LAY_LEFT,  SEL_AUX }: b = {code[NIB_W-1:0], {PAD_W{1'b0}}, status};
            {LAY_RIGHT, SEL_MAIN}: b = code[BUS_W-1:0];
            default:               b = {status, {PAD_W{1'b0}}, code[RES_W-1 -: NIB_W]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rbp_edge.sv
module rbp_edge (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    output logic fall_o,
    output logic rise_o
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy_i;
    end

    assign fall_o = busy_q & ~busy_i;
    assign rise_o = ~busy_q & busy_i;
endmodule

// File: rtl/rbp_capture.sv
module rbp_capture
    import rbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             flip_msb_i,
    input  logic [RES_W-1:0] code_i,
    output logic [RES_W-1:0] code_o
);
    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] coded;

    always_comb begin
        coded           = code_i;
        coded[RES_W-1]  = code_i[RES_W-1] ^ flip_msb_i;
    end

    always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (load_i) code_q <= coded;
    end

    assign code_o = code_q;
endmodule

// File: rtl/rbp_dma.sv
module rbp_dma (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)        req_q <= 1'b0;
        else if (set_i) req_q <= 1'b1;
        else if (clr_i) req_q <= 1'b0;
    end

    assign req_o = req_q;
endmodule

// File: rtl/rbp_port.sv
module rbp_port
    import rbp_pkg::*;
(
    input  layout_e          lay_i,
    input  bus_req_t         req_i,
    input  logic [RES_W-1:0] code_i,
    input  logic             status_i,
    output logic [BUS_W-1:0] data_o,
    output logic             aux_read_o
);
    logic active;

    assign active     = req_i.cs & req_i.rd;
    assign aux_read_o = active & (req_i.sel == SEL_AUX);

    always_comb begin
        if (active) data_o = pack_byte(lay_i, req_i.sel, code_i, status_i);
        else        data_o = '0;
    end
endmodule

// File: rtl/conv_byte_reader.sv
module conv_byte_reader
    import rbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_busy_i,
    input  logic [RES_W-1:0] conv_code_i,
    input  logic             cfg_left_i,
    input  logic             cfg_flip_msb_i,
    input  logic             bus_cs_i,
    input  logic             bus_rd_i,
    input  logic             bus_addr_i,
    output logic [BUS_W-1:0] bus_data_o,
    output logic             dma_req_o
);
    logic             busy_fall;
    logic             busy_rise;
    logic [RES_W-1:0] held_code;
    logic             aux_read;
    bus_req_t         bus_req;

    assign bus_req.cs  = bus_cs_i;
    assign bus_req.rd  = bus_rd_i;
    assign bus_req.sel = bytesel_e'(bus_addr_i);

    rbp_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .busy_i (conv_busy_i),
        .fall_o (busy_fall),
        .rise_o (busy_rise)
    );

    rbp_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .load_i     (busy_fall),
        .flip_msb_i (cfg_flip_msb_i),
        .code_i     (conv_code_i),
        .code_o     (held_code)
    );

    rbp_port u_port (
        .lay_i      (layout_e'(cfg_left_i)),
        .req_i      (bus_req),
        .code_i     (held_code),
        .status_i   (conv_busy_i),
        .data_o     (bus_data_o),
        .aux_read_o (aux_read)
    );

    rbp_dma u_dma (
        .clk   (clk),
        .rst   (rst),
        .set_i (busy_fall),
        .clr_i (aux_read | busy_rise),
        .req_o (dma_req_o)
    );
endmodule

// File: rtl/rbp_checker.sv
module rbp_checker
    import rbp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             conv_busy_i,
    input logic [RES_W-1:0] conv_code_i,
    input logic             cfg_flip_msb_i,
    input logic             bus_cs_i,
    input logic             bus_rd_i,
    input logic             bus_addr_i,
    input logic [BUS_W-1:0] bus_data_o,
    input logic             dma_req_o,
    input logic [RES_W-1:0] held_code
);
    logic busy_d;
    logic fall_seen;

    always_ff @(posedge clk) begin
        if (rst) busy_d <= 1'b0;
        else     busy_d <= conv_busy_i;
    end

    assign fall_seen = busy_d & ~conv_busy_i;

    // R1
    a_r1_req_low_after_reset: assert property (@(posedge clk)
        rst |=> !dma_req_o);

    // R2, R7
    a_r2_capture_on_fall: assert property (@(posedge clk) disable iff (rst)
        fall_seen |=> held_code == {$past(conv_code_i[RES_W-1] ^ cfg_flip_msb_i),
                                    $past(conv_code_i[RES_W-2:0])});

    // R8
    a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs_i && bus_rd_i) |-> bus_data_o == '0);

    // R9
    a_r9_req_after_fall: assert property (@(posedge clk) disable iff (rst)
        fall_seen |=> dma_req_o);

    // R10
    a_r10_aux_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_cs_i && bus_rd_i && bus_addr_i && !fall_seen) |=> !dma_req_o);

    // R11
    a_r11_rise_clears: assert property (@(posedge clk) disable iff (rst)
        (!busy_d && conv_busy_i) |=> !dma_req_o);

    // R12
    a_r12_hold_without_fall: assert property (@(posedge clk) disable iff (rst)
        !fall_seen |=> $stable(held_code));
endmodule

bind conv_byte_reader rbp_checker u_rbp_checker (
    .clk            (clk),
    .rst            (rst),
    .conv_busy_i    (conv_busy_i),
    .conv_code_i    (conv_code_i),
    .cfg_flip_msb_i (cfg_flip_msb_i),
    .bus_cs_i       (bus_cs_i),
    .bus_rd_i       (bus_rd_i),
    .bus_addr_i     (bus_addr_i),
    .bus_data_o     (bus_data_o),
    .dma_req_o      (dma_req_o),
    .held_code      (held_code)
);

// File: tb/test_conv_byte_reader.sv
module test_conv_byte_reader;

    logic        clk = 1'b0;
    logic        rst;
    logic        conv_busy_i;
    logic [11:0] conv_code_i;
    logic        cfg_left_i;
    logic        cfg_flip_msb_i;
    logic        bus_cs_i;
    logic        bus_rd_i;
    logic        bus_addr_i;
    logic [7:0]  bus_data_o;
    logic        dma_req_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    conv_byte_reader i_conv_byte_reader (
        .clk            (clk),
        .rst            (rst),
        .conv_busy_i    (conv_busy_i),
        .conv_code_i    (conv_code_i),
        .cfg_left_i     (cfg_left_i),
        .cfg_flip_msb_i (cfg_flip_msb_i),
        .bus_cs_i       (bus_cs_i),
        .bus_rd_i       (bus_rd_i),
        .bus_addr_i     (bus_addr_i),
        .bus_data_o     (bus_data_o),
        .dma_req_o      (dma_req_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Expected byte computed from the stated layouts
    function automatic logic [7:0] exp_byte(input logic left, input logic aux,
                                            input logic [11:0] r, input logic st);
        if (left && !aux)  return r[11:4];
        if (left && aux)   return {r[3:0], 3'b000, st};
        if (!left && !aux) return r[7:0];
        return {st, 3'b000, r[11:8]};
    endfunction

    // Combinational read: drive at negedge, check 1 ns later, then release
    task automatic rd_chk(input string req, input logic addr, input logic [7:0] exp);
        @(negedge clk);
        bus_cs_i = 1'b1; bus_rd_i = 1'b1; bus_addr_i = addr;
        #1;
        chk(req, bus_data_o, exp);
        @(negedge clk);
        bus_cs_i = 1'b0; bus_rd_i = 1'b0; bus_addr_i = 1'b0;
    endtask

    task automatic convert(input logic [11:0] code);
        @(negedge clk);
        conv_busy_i = 1'b1;
        conv_code_i = 12'h000;
        repeat (3) @(negedge clk);
        conv_code_i = code;
        conv_busy_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 dma after reset", {7'b0, dma_req_o}, 8'h00);
        chk("R8 idle output", bus_data_o, 8'h00);
        rd_chk("R1 main byte after reset", 1'b0, 8'h00);
        rd_chk("R1 aux byte after reset", 1'b1, 8'h00);
    endtask

    task automatic t_left;
        cfg_left_i = 1'b1; cfg_flip_msb_i = 1'b0;
        convert(12'hA5C);
        chk("R9 request after fall", {7'b0, dma_req_o}, 8'h01);
        rd_chk("R3 R2 left main", 1'b0, exp_byte(1'b1, 1'b0, 12'hA5C, 1'b0));
        chk("R10 main read keeps request", {7'b0, dma_req_o}, 8'h01);
        rd_chk("R4 left aux", 1'b1, exp_byte(1'b1, 1'b1, 12'hA5C, 1'b0));
        chk("R10 aux read clears request", {7'b0, dma_req_o}, 8'h00);
    endtask

    task automatic t_right;
        cfg_left_i = 1'b0; cfg_flip_msb_i = 1'b0;
        convert(12'h3E7);
        rd_chk("R5 right main", 1'b0, 8'hE7);
        rd_chk("R6 right aux", 1'b1, 8'h03);
    endtask

    task automatic t_status_and_hold;
        // Held result is 0x3E7; start a conversion and drive new data lines
        @(negedge clk);
        conv_busy_i = 1'b1;
        conv_code_i = 12'hFFF;
        cfg_left_i  = 1'b0;
        rd_chk("R6 status bit while busy", 1'b1, 8'h83);
        rd_chk("R12 main held during conversion", 1'b0, 8'hE7);
        cfg_left_i = 1'b1;
        rd_chk("R4 left status bit while busy", 1'b1, 8'h71);
        @(negedge clk);
        conv_busy_i = 1'b0;
        conv_code_i = 12'h124;
        @(negedge clk);
        conv_code_i = 12'h9AB;
        rd_chk("R12 unchanged without new fall", 1'b0, 8'h12);
        rd_chk("R12 aux unchanged", 1'b1, 8'h40);
    endtask

    task automatic t_rise_clears;
        cfg_left_i = 1'b1;
        convert(12'h456);
        chk("R9 request set", {7'b0, dma_req_o}, 8'h01);
        @(negedge clk);
        conv_busy_i = 1'b1;
        @(negedge clk);
        chk("R11 rise clears request", {7'b0, dma_req_o}, 8'h00);
        conv_busy_i = 1'b0;
        @(negedge clk);
        chk("R9 second request", {7'b0, dma_req_o}, 8'h01);
    endtask

    task automatic t_gating;
        @(negedge clk);
        bus_cs_i = 1'b1; bus_rd_i = 1'b0; bus_addr_i = 1'b0;
        #1 chk("R8 strobe low", bus_data_o, 8'h00);
        bus_cs_i = 1'b0; bus_rd_i = 1'b1;
        #1 chk("R8 select low", bus_data_o, 8'h00);
        bus_rd_i = 1'b0;
        @(negedge clk);
        chk("R10 request kept after non-reads", {7'b0, dma_req_o}, 8'h01);
    endtask

    task automatic t_flip;
        cfg_left_i = 1'b1; cfg_flip_msb_i = 1'b1;
        convert(12'h800);
        rd_chk("R7 flip 0x800 main", 1'b0, 8'h00);
        convert(12'h7FF);
        rd_chk("R7 flip 0x7FF main", 1'b0, 8'hFF);
        rd_chk("R7 flip 0x7FF aux", 1'b1, 8'hF0);
        cfg_left_i = 1'b0;
        rd_chk("R7 right nibble flipped", 1'b1, 8'h0F);
        cfg_flip_msb_i = 1'b0;
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: actual hung, expected run complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        conv_busy_i = 1'b0; conv_code_i = 12'h000;
        cfg_left_i = 1'b1; cfg_flip_msb_i = 1'b0;
        bus_cs_i = 1'b0; bus_rd_i = 1'b0; bus_addr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_left();
        t_right();
        t_status_and_hold();
        t_rise_clears();
        t_gating();
        t_flip();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule